// File: doc/BRIEF.md
# Step-Down Converter Mode Controller

This block is the digital sequencer that sits beside a buck converter with three operating modes. In bypass the converter input is tied straight to its output. In switching regulation (SMPS mode) the converter drives the output to a programmed target. In open mode the output is disconnected and the bulk capacitor keeps its charge. The block holds the software settings: enable, output voltage code, current-limit code, brown-out policy, interrupt enable and a settle limit. It sequences the modes from those settings and from four inputs: a high-threshold brown-out comparator, a low-power stop request, an output-above-1.4 V comparator and an output-at-target comparator.

A brown-out can either ask the system for a reset or push the converter back into bypass. In the second case a sticky forced-bypass flag is raised and can interrupt the CPU. Software must clear that flag and enable the converter again before regulation resumes. When the chip stops, the converter moves to open mode. When the stop ends, the converter clock and the CPU are both held until the output comparator reports at least 1.4 V. The block also reports the target voltage in millivolts and the current limit in milliamps. A settle timer flags a ramp that takes too long.

Top module: `buck_mode_ctrl`

## Requirements
- R1: After reset the controller is in bypass. The mode output encodes bypass as 2'b00, SMPS as 2'b01 and open as 2'b10. The bypass flag is 1, the CPU is released, and ready, forced-bypass, irq, reset request and converter clock enable are 0. The configuration word (bit 0 enable, bits 4:1 voltage code, bits 7:5 current-limit code, bit 8 brown-out policy, bit 9 interrupt enable, bit 10 write-only flag clear, bits 11 and up settle limit) reads back enable 0, voltage code equal to the coarse trim input, current code 7, policy 0, interrupt enable 0 and settle limit 200.
- R2: One clock after enable is written to 1, the mode output is SMPS and ready is 0. Ready becomes 1 after the first clock edge at which the target comparator is sampled high.
- R3: If the policy bit is 1, the high brown-out input is high at a clock edge and enable is 1, then after that edge the mode is bypass, the forced-bypass flag is 1 and enable reads 0. While the flag is 1, setting enable alone does not leave bypass.
- R4: If the policy bit is 0, a high brown-out input drives the reset request high one clock later, and the mode is unchanged.
- R5: The irq output is 1 one clock after the forced-bypass flag is 1 with interrupt enable 1, and stays 0 when interrupt enable is 0. Writing bit 10 as 1 clears the flag. Bit 10 always reads 0.
- R6: The bypass flag is 1 exactly when the mode output is bypass, and 0 in SMPS and open.
- R7: A stop request while in SMPS mode moves the converter to open after one clock. In open mode the converter clock enable is 0 and the CPU is held.
- R8: After the stop request drops, the mode stays open and the CPU stays held for as long as the output comparator is low. One clock after the comparator is sampled high, the mode is SMPS, the clock enable is 1, the CPU is released and ready is 0.
- R9: The target output equals 1500 + (voltage code - trim) x 50 mV. It updates one clock after the code register changes. The code is reloaded from the trim value at reset and on standby wake.
- R10: The current limit output equals 80 + code x 20 mA. It updates one clock after the code register changes.
- R11: A standby wake pulse returns the mode to bypass and reloads the voltage code. Enable, current code, policy, interrupt enable and the forced-bypass flag keep their values.
- R12: When the target comparator stays low, the settle error output goes to 1 after L+1 clocks in SMPS mode without ready, where L is the settle limit. It returns to 0 at the edge where ready rises.
- R13: Writing a different voltage code while ready is 1 drops ready at that write edge, and the mode stays SMPS until the new target is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| trim_coarse | input | 4 | Factory coarse trim code, loaded at reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 19 | Configuration word write data |
| cfg_rdata | output | 19 | Configuration word readback (bit 10 reads 0) |
| stby_wake | input | 1 | Single-cycle pulse on exit from standby |
| bor_hi | input | 1 | High-threshold brown-out comparator |
| lp_req | input | 1 | Stop-mode request, high while stopped |
| vout_ok | input | 1 | Output at or above 1.4 V |
| tgt_reached | input | 1 | Output at the programmed target |
| mode | output | 2 | Converter mode: 00 bypass, 01 SMPS, 10 open |
| sw_clk_en | output | 1 | Converter switching clock enable |
| cpu_release | output | 1 | CPU may run |
| rdy_flag | output | 1 | Regulating at target |
| byp_flag | output | 1 | Converter in bypass |
| fbyp_flag | output | 1 | Sticky forced-bypass flag |
| irq | output | 1 | Forced-bypass interrupt |
| rst_req | output | 1 | System reset request from brown-out |
| settle_err | output | 1 | Ramp exceeded the settle limit |
| vout_target_mv | output | 12 | Programmed target in millivolts |
| ilim_ma | output | 8 | Programmed current limit in milliamps |

## Verification
The assertions assume that all comparator and request inputs are synchronous to the clock and that the standby wake is a single-cycle pulse. They also assume software sends at most one configuration write per clock. The stimulus changes inputs only just after a rising edge and raises one event at a time. It never raises a brown-out in the same cycle as a stop request or a wake pulse. This keeps the priority between concurrent events out of the expected values. The target and current-limit checks sweep every code under two trim values. The settle check sweeps limits 0 to 7.

// File: rtl/buck_pkg.sv
package buck_pkg;
  // configuration word layout
  localparam int EN_BIT    = 0;
  localparam int VOS_LSB   = 1;
  localparam int VOS_W     = 4;
  localparam int ILIM_LSB  = 5;
  localparam int ILIM_W    = 3;
  localparam int BORC_BIT  = 8;
  localparam int IRQEN_BIT = 9;
  localparam int CLR_BIT   = 10;
  localparam int LIM_LSB   = 11;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_SMPS   = 2'b01,
    MODE_OPEN   = 2'b10
  } mode_e;

  typedef enum logic [2:0] {
    ST_BYP  = 3'd0,
    ST_RAMP = 3'd1,
    ST_RUN  = 3'd2,
    ST_OPEN = 3'd3,
    ST_WAKE = 3'd4
  } state_e;
endpackage

// File: rtl/buck_cfg_regs.sv
module buck_cfg_regs
  import buck_pkg::*;
#(
  parameter int LIM_W    = 8,
  parameter int LIM_RST  = 200,
  parameter int ILIM_RST = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [VOS_W-1:0]         trim_coarse,
  input  logic                     cfg_we,
  input  logic [LIM_LSB+LIM_W-1:0] cfg_wdata,
  input  logic                     stby_wake,
  input  logic                     bor_hi,
  output logic [LIM_LSB+LIM_W-1:0] cfg_rdata,
  output logic                     en_q,
  output logic [VOS_W-1:0]         vos_q,
  output logic [VOS_W-1:0]         trim_q,
  output logic [ILIM_W-1:0]        ilim_q,
  output logic [LIM_W-1:0]         lim_q,
  output logic                     fbyp_q,
  output logic                     irq_q,
  output logic                     rst_req_q,
  output logic                     force_byp,
  output logic                     vos_chg
);
  logic             borc_q;
  logic             irqen_q;
  logic [VOS_W-1:0] wr_vos;

  assign wr_vos    = cfg_wdata[VOS_LSB +: VOS_W];
  assign force_byp = bor_hi && borc_q && en_q;
  assign vos_chg   = cfg_we && (wr_vos != vos_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      vos_q     <= trim_coarse;
      trim_q    <= trim_coarse;
      ilim_q    <= ILIM_W'(ILIM_RST);
      lim_q     <= LIM_W'(LIM_RST);
      borc_q    <= 1'b0;
      irqen_q   <= 1'b0;
      fbyp_q    <= 1'b0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      irq_q     <= fbyp_q && irqen_q;
      rst_req_q <= bor_hi && !borc_q;
      if (stby_wake) begin
        vos_q <= trim_q;
      end else if (cfg_we) begin
        en_q    <= cfg_wdata[EN_BIT];
        vos_q   <= wr_vos;
        ilim_q  <= cfg_wdata[ILIM_LSB +: ILIM_W];
        borc_q  <= cfg_wdata[BORC_BIT];
        irqen_q <= cfg_wdata[IRQEN_BIT];
        lim_q   <= cfg_wdata[LIM_LSB +: LIM_W];
        if (cfg_wdata[CLR_BIT]) fbyp_q <= 1'b0;
      end
      if (force_byp) begin
        en_q   <= 1'b0;
        fbyp_q <= 1'b1;
      end
    end
  end

  always_comb begin
    cfg_rdata                        = '0;
    cfg_rdata[EN_BIT]                = en_q;
    cfg_rdata[VOS_LSB +: VOS_W]      = vos_q;
    cfg_rdata[ILIM_LSB +: ILIM_W]    = ilim_q;
    cfg_rdata[BORC_BIT]              = borc_q;
    cfg_rdata[IRQEN_BIT]             = irqen_q;
    cfg_rdata[LIM_LSB +: LIM_W]      = lim_q;
  end

  AST_FORCE_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
    force_byp |=> (!en_q && fbyp_q)); // R3
  AST_BOR_RESET_REQ: assert property (@(posedge clk) disable iff (rst)
    (bor_hi && !borc_q) |=> rst_req_q); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[CLR_BIT] && !force_byp && !stby_wake) |=> !fbyp_q); // R5
  AST_WAKE_RETAINS: assert property (@(posedge clk) disable iff (rst)
    (stby_wake && !force_byp) |=> (en_q == $past(en_q) && ilim_q == $past(ilim_q)
                                   && fbyp_q == $past(fbyp_q))); // R11
endmodule

// File: rtl/buck_mode_fsm.sv
module buck_mode_fsm
  import buck_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  stby_wake,
  input  logic  en_q,
  input  logic  fbyp_q,
  input  logic  force_byp,
  input  logic  vos_chg,
  input  logic  lp_req,
  input  logic  vout_ok,
  input  logic  tgt_reached,
  output mode_e mode_q,
  output logic  clk_en_q,
  output logic  cpu_q,
  output logic  rdy_q,
  output logic  byp_q,
  output logic  in_ramp
);
  state_e st_q, st_d;

  function automatic mode_e mode_of(state_e s);
    case (s)
      ST_RAMP, ST_RUN:  return MODE_SMPS;
      ST_OPEN, ST_WAKE: return MODE_OPEN;
      default:          return MODE_BYPASS;
    endcase
  endfunction

  always_comb begin
    st_d = st_q;
    if (stby_wake || force_byp) begin
      st_d = ST_BYP;
    end else begin
      case (st_q)
        ST_BYP:  if (en_q && !fbyp_q) st_d = ST_RAMP;
        ST_RAMP: begin
          if (!en_q)            st_d = ST_BYP;
          else if (lp_req)      st_d = ST_OPEN;
          else if (tgt_reached) st_d = ST_RUN;
        end
        ST_RUN: begin
          if (!en_q)        st_d = ST_BYP;
          else if (lp_req)  st_d = ST_OPEN;
          else if (vos_chg) st_d = ST_RAMP;
        end
        ST_OPEN: begin
          if (!en_q)        st_d = ST_BYP;
          else if (!lp_req) st_d = ST_WAKE;
        end
        ST_WAKE: begin
          if (!en_q)        st_d = ST_BYP;
          else if (lp_req)  st_d = ST_OPEN;
          else if (vout_ok) st_d = ST_RAMP;
        end
        default: st_d = ST_BYP;
      endcase
    end
  end

  // outputs registered from the next state so they change with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_BYP;
      mode_q   <= MODE_BYPASS;
      clk_en_q <= 1'b0;
      cpu_q    <= 1'b1;
      rdy_q    <= 1'b0;
      byp_q    <= 1'b1;
    end else begin
      st_q     <= st_d;
      mode_q   <= mode_of(st_d);
      clk_en_q <= (st_d == ST_RAMP) || (st_d == ST_RUN);
      cpu_q    <= !((st_d == ST_OPEN) || (st_d == ST_WAKE));
      rdy_q    <= (st_d == ST_RUN);
      byp_q    <= (st_d == ST_BYP);
    end
  end

  assign in_ramp = (st_q == ST_RAMP);

  AST_READY_NEEDS_TARGET: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(tgt_reached)); // R2
  AST_WAKE_NEEDS_VOUT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RAMP && $past(st_q) == ST_WAKE) |-> $past(vout_ok)); // R8
  AST_STOP_OPENS: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_RUN || st_q == ST_RAMP) && en_q && lp_req && !force_byp && !stby_wake)
      |=> (mode_q == MODE_OPEN && !cpu_q && !clk_en_q)); // R7
  AST_FORCED_STAYS_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (fbyp_q && st_q == ST_BYP) |=> byp_q); // R3
endmodule

// File: rtl/buck_settle_timer.sv
module buck_settle_timer #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_ramp,
  input  logic             tgt_reached,
  input  logic [LIM_W-1:0] lim,
  output logic             err_q
);
  logic [LIM_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (!in_ramp) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (tgt_reached)      err_q <= 1'b0;
      else if (cnt_q == lim) err_q <= 1'b1;
    end
  end

  AST_ERR_NEEDS_MISS: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(in_ramp && !tgt_reached)); // R12
  AST_ERR_CLEARS_ON_TARGET: assert property (@(posedge clk) disable iff (rst)
    (in_ramp && tgt_reached) |=> !err_q); // R12
endmodule

// File: rtl/buck_scale.sv
module buck_scale
  import buck_pkg::*;
#(
  parameter int BASE_MV      = 1500,
  parameter int STEP_MV      = 50,
  parameter int ILIM_BASE_MA = 80,
  parameter int ILIM_STEP_MA = 20,
  parameter int MV_W         = 12,
  parameter int MA_W         = 8,
  parameter bit REG_OUT      = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VOS_W-1:0]  vos,
  input  logic [VOS_W-1:0]  trim,
  input  logic [ILIM_W-1:0] ilim,
  output logic [MV_W-1:0]   mv,
  output logic [MA_W-1:0]   ma
);
  logic [MV_W-1:0] mv_c;
  logic [MA_W-1:0] ma_c;

  always_comb begin
    mv_c = MV_W'(BASE_MV + (int'(vos) - int'(trim)) * STEP_MV);
    ma_c = MA_W'(ILIM_BASE_MA + int'(ilim) * ILIM_STEP_MA);
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          mv <= '0;
          ma <= '0;
        end else begin
          mv <= mv_c;
          ma <= ma_c;
        end
      end
    end else begin : g_comb
      assign mv = mv_c;
      assign ma = ma_c;
    end
  endgenerate
endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
  import buck_pkg::*;
#(
  parameter int LIM_W        = 8,
  parameter int LIM_RST      = 200,
  parameter int ILIM_RST     = 7,
  parameter int BASE_MV      = 1500,
  parameter int STEP_MV      = 50,
  parameter int ILIM_BASE_MA = 80,
  parameter int ILIM_STEP_MA = 20,
  parameter int MV_W         = 12,
  parameter int MA_W         = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [VOS_W-1:0]         trim_coarse,
  input  logic                     cfg_we,
  input  logic [LIM_LSB+LIM_W-1:0] cfg_wdata,
  output logic [LIM_LSB+LIM_W-1:0] cfg_rdata,
  input  logic                     stby_wake,
  input  logic                     bor_hi,
  input  logic                     lp_req,
  input  logic                     vout_ok,
  input  logic                     tgt_reached,
  output logic [1:0]               mode,
  output logic                     sw_clk_en,
  output logic                     cpu_release,
  output logic                     rdy_flag,
  output logic                     byp_flag,
  output logic                     fbyp_flag,
  output logic                     irq,
  output logic                     rst_req,
  output logic                     settle_err,
  output logic [MV_W-1:0]          vout_target_mv,
  output logic [MA_W-1:0]          ilim_ma
);
  logic              en_q, fbyp_q, force_byp, vos_chg, in_ramp;
  logic [VOS_W-1:0]  vos_q, trim_q;
  logic [ILIM_W-1:0] ilim_q;
  logic [LIM_W-1:0]  lim_q;
  mode_e             mode_q;

  buck_cfg_regs #(.LIM_W(LIM_W), .LIM_RST(LIM_RST), .ILIM_RST(ILIM_RST)) i_cfg (
    .clk(clk), .rst(rst), .trim_coarse(trim_coarse), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .stby_wake(stby_wake), .bor_hi(bor_hi),
    .cfg_rdata(cfg_rdata), .en_q(en_q), .vos_q(vos_q), .trim_q(trim_q),
    .ilim_q(ilim_q), .lim_q(lim_q), .fbyp_q(fbyp_q), .irq_q(irq),
    .rst_req_q(rst_req), .force_byp(force_byp), .vos_chg(vos_chg)
  );

  buck_mode_fsm i_fsm (
    .clk(clk), .rst(rst), .stby_wake(stby_wake), .en_q(en_q), .fbyp_q(fbyp_q),
    .force_byp(force_byp), .vos_chg(vos_chg), .lp_req(lp_req), .vout_ok(vout_ok),
    .tgt_reached(tgt_reached), .mode_q(mode_q), .clk_en_q(sw_clk_en),
    .cpu_q(cpu_release), .rdy_q(rdy_flag), .byp_q(byp_flag), .in_ramp(in_ramp)
  );

  buck_settle_timer #(.LIM_W(LIM_W)) i_settle (
    .clk(clk), .rst(rst), .in_ramp(in_ramp), .tgt_reached(tgt_reached),
    .lim(lim_q), .err_q(settle_err)
  );

  buck_scale #(
    .BASE_MV(BASE_MV), .STEP_MV(STEP_MV), .ILIM_BASE_MA(ILIM_BASE_MA),
    .ILIM_STEP_MA(ILIM_STEP_MA), .MV_W(MV_W), .MA_W(MA_W), .REG_OUT(1'b1)
  ) i_scale (
    .clk(clk), .rst(rst), .vos(vos_q), .trim(trim_q), .ilim(ilim_q),
    .mv(vout_target_mv), .ma(ilim_ma)
  );

  assign mode      = mode_q;
  assign fbyp_flag = fbyp_q;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!fbyp_flag && !$past(fbyp_flag)) |-> !irq); // R5
  AST_BYPASS_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    byp_flag == (mode == 2'b00)); // R6
endmodule

// File: tb/test_buck_mode_ctrl.sv
module test_buck_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LIM_W = 8;
  localparam int CFG_W = 11 + LIM_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] trim_coarse = 4'd7;
  logic cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic [CFG_W-1:0] cfg_rdata;
  logic stby_wake = 1'b0, bor_hi = 1'b0, lp_req = 1'b0, vout_ok = 1'b0, tgt_reached = 1'b0;
  logic [1:0] mode;
  logic sw_clk_en, cpu_release, rdy_flag, byp_flag, fbyp_flag, irq, rst_req, settle_err;
  logic [11:0] vout_target_mv;
  logic [7:0] ilim_ma;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_mode_ctrl #(.LIM_W(LIM_W)) i_buck_mode_ctrl (
    .clk(clk), .rst(rst), .trim_coarse(trim_coarse), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stby_wake(stby_wake),
    .bor_hi(bor_hi), .lp_req(lp_req), .vout_ok(vout_ok), .tgt_reached(tgt_reached),
    .mode(mode), .sw_clk_en(sw_clk_en), .cpu_release(cpu_release), .rdy_flag(rdy_flag),
    .byp_flag(byp_flag), .fbyp_flag(fbyp_flag), .irq(irq), .rst_req(rst_req),
    .settle_err(settle_err), .vout_target_mv(vout_target_mv), .ilim_ma(ilim_ma)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] mk(bit en, int vos, int il, bit borc, bit ien, bit clr, int lim);
    logic [CFG_W-1:0] w;
    w = '0;
    w[0] = en;
    w[4:1] = 4'(vos);
    w[7:5] = 3'(il);
    w[8] = borc;
    w[9] = ien;
    w[10] = clr;
    w[CFG_W-1:11] = LIM_W'(lim);
    return w;
  endfunction

  task automatic wr(logic [CFG_W-1:0] w);
    cfg_we = 1'b1;
    cfg_wdata = w;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int tr;
    // two trim values: reset state, full voltage-code and current-code sweeps
    for (int t = 0; t < 2; t++) begin
      tr = (t == 0) ? 7 : 4;
      trim_coarse = 4'(tr);
      rst = 1'b1;
      repeat (3) tick();
      rst = 1'b0;
      chk("R1 mode", mode, 0);
      chk("R1 bypass flag", byp_flag, 1);
      chk("R1 ready", rdy_flag, 0);
      chk("R1 forced", fbyp_flag, 0);
      chk("R1 irq", irq, 0);
      chk("R1 reset req", rst_req, 0);
      chk("R1 cpu release", cpu_release, 1);
      chk("R1 clk enable", sw_clk_en, 0);
      chk("R1 config word", cfg_rdata, mk(0, tr, 7, 0, 0, 0, 200));
      tick();
      chk("R9 target at trim", vout_target_mv, 1500);
      chk("R10 default limit", ilim_ma, 220);
      for (int v = 0; v < 16; v++) begin
        wr(mk(0, v, 7, 0, 0, 0, 200));
        tick();
        chk("R9 target", vout_target_mv, 1500 + (v - tr) * 50);
      end
      for (int c = 0; c < 8; c++) begin
        wr(mk(0, tr, c, 0, 0, 0, 200));
        tick();
        chk("R10 current limit", ilim_ma, 80 + c * 20);
      end
    end
    // trim is 4 from here on
    wr(mk(1, 6, 7, 0, 0, 0, 200));
    chk("R2 still bypass at write", mode, 0);
    tick();
    chk("R2 mode smps", mode, 1);
    chk("R6 bypass flag in smps", byp_flag, 0);
    chk("R2 clk enable", sw_clk_en, 1);
    repeat (3) tick();
    chk("R2 not ready before target", rdy_flag, 0);
    tgt_reached = 1'b1;
    tick();
    chk("R2 ready", rdy_flag, 1);
    // R13: code change while ready
    tgt_reached = 1'b0;
    wr(mk(1, 9, 7, 0, 0, 0, 200));
    chk("R13 ready drops", rdy_flag, 0);
    chk("R13 mode smps", mode, 1);
    tick();
    chk("R13 still not ready", rdy_flag, 0);
    tgt_reached = 1'b1;
    tick();
    chk("R13 ready again", rdy_flag, 1);
    // stop entry and exit
    lp_req = 1'b1;
    tick();
    chk("R7 mode open", mode, 2);
    chk("R7 clk off", sw_clk_en, 0);
    chk("R7 cpu held", cpu_release, 0);
    chk("R6 bypass flag in open", byp_flag, 0);
    lp_req = 1'b0;
    vout_ok = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R8 waits for output", mode, 2);
      chk("R8 cpu held", cpu_release, 0);
    end
    vout_ok = 1'b1;
    tick();
    chk("R8 mode smps", mode, 1);
    chk("R8 clk on", sw_clk_en, 1);
    chk("R8 cpu released", cpu_release, 1);
    chk("R8 ready low", rdy_flag, 0);
    tick();
    chk("R8 ready after target", rdy_flag, 1);
    vout_ok = 1'b0;
    // brown-out with reset policy
    bor_hi = 1'b1;
    tick();
    chk("R4 reset request", rst_req, 1);
    chk("R4 mode unchanged", mode, 1);
    chk("R4 no forced flag", fbyp_flag, 0);
    bor_hi = 1'b0;
    tick();
    chk("R4 request released", rst_req, 0);
    // brown-out with bypass policy, interrupt on
    wr(mk(1, 9, 7, 1, 1, 0, 200));
    bor_hi = 1'b1;
    tick();
    bor_hi = 1'b0;
    chk("R3 mode bypass", mode, 0);
    chk("R6 bypass flag", byp_flag, 1);
    chk("R3 forced flag", fbyp_flag, 1);
    chk("R3 enable cleared", cfg_rdata[0], 0);
    chk("R3 no reset request", rst_req, 0);
    tick();
    chk("R5 irq raised", irq, 1);
    wr(mk(1, 9, 7, 1, 1, 0, 200));
    tick();
    tick();
    chk("R3 stays bypass without clear", mode, 0);
    wr(mk(1, 9, 7, 1, 1, 1, 200));
    chk("R5 flag cleared", fbyp_flag, 0);
    chk("R5 clear bit reads zero", cfg_rdata[10], 0);
    tick();
    chk("R3 smps after clear and enable", mode, 1);
    chk("R5 irq dropped", irq, 0);
    // interrupt disabled
    wr(mk(1, 9, 7, 1, 0, 0, 200));
    bor_hi = 1'b1;
    tick();
    bor_hi = 1'b0;
    chk("R3 forced again", fbyp_flag, 1);
    tick();
    tick();
    chk("R5 irq masked", irq, 0);
    wr(mk(1, 12, 3, 1, 1, 1, 200));
    tick();
    chk("R11 smps before wake", mode, 1);
    // standby wake
    stby_wake = 1'b1;
    tick();
    stby_wake = 1'b0;
    chk("R11 bypass on wake", mode, 0);
    chk("R11 retained word", cfg_rdata, mk(1, 4, 3, 1, 1, 0, 200));
    tick();
    chk("R11 enable resumes", mode, 1);
    chk("R9 target after reload", vout_target_mv, 1500);
    // settle limit sweep
    tgt_reached = 1'b0;
    for (int lim = 0; lim < 8; lim++) begin
      int n;
      wr(mk(0, 4, 7, 1, 1, 0, lim));
      tick();
      wr(mk(1, 4, 7, 1, 1, 0, lim));
      tick();
      chk("R12 no error at ramp start", settle_err, 0);
      n = 0;
      while (!settle_err && n < 40) begin
        tick();
        n++;
      end
      chk("R12 clocks to error", n, lim + 1);
      tgt_reached = 1'b1;
      tick();
      chk("R12 error clears", settle_err, 0);
      chk("R12 ready", rdy_flag, 1);
      tgt_reached = 1'b0;
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule